// File: doc/BRIEF.md
# Interrupt Coalescing Delay Timer

This block sits between one DMA channel's completion strobe and that channel's interrupt line. Its purpose is to reduce the interrupt rate when the channel finishes many small jobs in quick succession. Software programs a hold-off period, counted in microseconds, through a single 16-bit register. The first completion that arrives while the block is idle opens a window. Any completion that arrives while the window is open is folded into that window. When the window closes, the block raises exactly one interrupt pulse.

A free-running prescaler derives a one-microsecond tick from the system clock. A period of zero switches moderation off, so that every completion is passed straight through as its own interrupt pulse. The same register also carries a read-only capability flag and a reserved bit. This lets software read back the period that actually took effect.

Top module: `irq_coalesce_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the stored period, the pending flag and the counter are cleared, and `irq_pulse` is low after that edge. Once reset is released, a read at the register offset returns 16'h8000.
- R2: In the value read back, bit 15 is always 1 and bit 14 is always 0, whatever value was written to those two bits.
- R3: A write at the register offset (parameter `REG_OFFSET`, default 8'h0C) stores `reg_wdata[13:0]` as the period. A read at that offset then returns the stored period in bits 13:0, including the maximum value 14'h3FFF.
- R4: A write to any other address leaves the period unchanged. A read from any other address returns 0.
- R5: When no window is open and the period is 0, `irq_pulse` is high for the one cycle after each clock edge at which `done_evt` was sampled high. Back-to-back events therefore give back-to-back pulses.
- R6: The prescaler gives one tick every `CLKS_PER_US` cycles. The first tick falls on the `CLKS_PER_US`-th clock edge after reset is released, and the ticks run without regard to event traffic.
- R7: An event sampled while idle with a nonzero period N opens a window and loads the counter with N. Each later tick edge lowers the counter by one. At the first edge where the counter is already 0, `irq_pulse` goes high for one cycle and the block returns to idle.
- R8: Events sampled while a window is open, including the edge at which it closes, do not restart the counter and produce no extra pulse.
- R9: A period written while a window is open does not change that window's count. It applies from the next window on, and a write of 0 makes the next event bypass moderation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| done_evt | input | 1 | Completion strobe from the channel, one per finished job |
| irq_pulse | output | 1 | Coalesced interrupt, one cycle per pulse |

## Verification
The hardest situation to create from the ports is an event or a period write that lands exactly on the edge where a window closes, or just after it. Here the difference between absorbing the event and arming a fresh window comes down to a single cycle.

The stimulus makes this likely by using short periods and a small prescaler ratio. It drives bursts of events at a high random density and mixes random period rewrites into open windows. A per-cycle reference model judges every edge, so every collision that occurs is checked. One directed run holds a window open for the full 14'h3FFF microseconds to cover the counter's upper bound.

// File: rtl/irq_coalesce_timer.sv
module irq_coalesce_timer #(
  parameter int          CLKS_PER_US = 200,
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  REG_OFFSET  = 8'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              done_evt,
  output logic              irq_pulse
);
  localparam int PER_W = 14;
  localparam int PS_W  = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLKS_PER_US - 1);

  logic [PS_W-1:0]  ps_q;
  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] cnt_q;
  logic             pending_q;
  logic             irq_q;

  wire sel    = (reg_addr == ADDR_W'(REG_OFFSET));
  wire tick   = (ps_q == PS_LAST);
  wire expire = pending_q && (cnt_q == '0);
  wire bypass = !pending_q && (period_q == '0) && done_evt;
  wire arm    = !pending_q && (period_q != '0) && done_evt;

  assign reg_rdata = sel ? {1'b1, 1'b0, period_q} : 16'h0000;
  assign irq_pulse = irq_q;

  always_ff @(posedge clk) begin
    if (rst) ps_q <= '0;
    else     ps_q <= tick ? '0 : ps_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                period_q <= '0;
    else if (reg_wr && sel) period_q <= reg_wdata[PER_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= expire || bypass;
      if (expire) begin
        pending_q <= 1'b0;
      end else if (pending_q) begin
        if (tick) cnt_q <= cnt_q - 1'b1;
      end else if (arm) begin
        pending_q <= 1'b1;
        cnt_q     <= period_q;
      end
    end
  end
endmodule

// File: rtl/irq_coalesce_timer_chk.sv
module irq_coalesce_timer_chk #(
  parameter int CLKS_PER_US = 200
) (
  input logic        clk,
  input logic        rst,
  input logic        evt,
  input logic        irq,
  input logic        pending,
  input logic [13:0] cnt,
  input logic [13:0] period,
  input logic        tick,
  input logic        sel,
  input logic [15:0] rdata
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!irq && !pending && period == 14'd0));

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    sel |-> (rdata[15] && !rdata[14]));

  a_r5_bypass_pulse: assert property (@(posedge clk) disable iff (rst)
    (!pending && period == 14'd0 && evt) |=> irq);

  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (CLKS_PER_US > 1 && tick) |=> !tick);

  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((pending && cnt == 14'd0) || (!pending && period == 14'd0 && evt)));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (pending && cnt != 14'd0) |=> (pending && (cnt == $past(cnt) || cnt == $past(cnt) - 14'd1)));

  a_r9_count_from_tick: assert property (@(posedge clk) disable iff (rst)
    (pending && cnt != 14'd0 && !tick) |=> $stable(cnt));
endmodule

bind irq_coalesce_timer irq_coalesce_timer_chk #(.CLKS_PER_US(CLKS_PER_US)) u_chk (
  .clk(clk), .rst(rst), .evt(done_evt), .irq(irq_pulse), .pending(pending_q),
  .cnt(cnt_q), .period(period_q), .tick(tick), .sel(sel), .rdata(reg_rdata)
);

// File: tb/irq_coalesce_timer_tb.sv
module irq_coalesce_timer_tb;
  localparam int C = 4;
  localparam logic [7:0] OFS = 8'h0C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] reg_addr = OFS;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic done_evt = 1'b0;
  logic irq_pulse;

  int n_chk = 0, n_bad = 0;
  string tag = "R5";

  // reference model state
  int m_pc = 0, m_cnt = 0, m_per = 0;
  bit m_pend = 0, m_irq = 0;

  irq_coalesce_timer #(.CLKS_PER_US(C), .ADDR_W(8), .REG_OFFSET(OFS)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done_evt(done_evt), .irq_pulse(irq_pulse)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] exp_read(logic [7:0] a, int per);
    return (a == OFS) ? {2'b10, 14'(per)} : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_pend = 0; m_cnt = 0; m_irq = 0; m_per = 0;
    end else begin
      bit tk;
      tk = (m_pc == C - 1);
      m_pc = tk ? 0 : m_pc + 1;
      m_irq = 0;
      if (m_pend) begin
        if (m_cnt == 0) begin m_irq = 1; m_pend = 0; end
        else if (tk) m_cnt = m_cnt - 1;
      end else if (done_evt) begin
        if (m_per == 0) m_irq = 1;
        else begin m_pend = 1; m_cnt = m_per; end
      end
      if (reg_wr && reg_addr == OFS) m_per = int'(reg_wdata[13:0]);
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (!rst) begin
    check(tag, {15'd0, irq_pulse}, {15'd0, m_irq});
    check("R2", reg_rdata, exp_read(reg_addr, m_per));
  end

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_addr = OFS;
  endtask

  task automatic run(int cycles, int pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      done_evt = ($urandom_range(99) < pct);
    end
    @(negedge clk); done_evt = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", {15'd0, irq_pulse}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", reg_rdata, 16'h8000);

    tag = "R3";
    wr(OFS, 16'hFFFF);
    check("R2", reg_rdata, 16'hBFFF);
    wr(OFS, 16'h4005);
    check("R3", reg_rdata, 16'h8005);
    wr(8'h0E, 16'h0123);
    reg_addr = 8'h0E; #1;
    check("R4", reg_rdata, 16'h0000);
    reg_addr = OFS; #1;
    check("R4", reg_rdata, 16'h8005);

    tag = "R5";
    wr(OFS, 16'h0000);
    run(40, 70);
    tag = "R6";
    wr(OFS, 16'h0001);
    @(negedge clk); done_evt = 1'b1; @(negedge clk); done_evt = 1'b0;
    repeat (12) @(negedge clk);

    tag = "R7";
    wr(OFS, 16'h0003);
    run(200, 10);
    tag = "R8";
    run(300, 80);

    tag = "R9";
    for (int k = 0; k < 60; k++) begin
      wr(OFS, 16'($urandom_range(6)));
      run($urandom_range(30, 5), $urandom_range(90, 10));
    end

    tag = "R3";
    wr(OFS, 16'h3FFF);
    check("R3", reg_rdata, 16'hBFFF);
    @(negedge clk); done_evt = 1'b1; @(negedge clk); done_evt = 1'b0;
    wr(OFS, 16'h0002);
    tag = "R7";
    repeat (16383 * C + 20) @(negedge clk);
    run(60, 30);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule